// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the instruction fetch address for a pipelined core whose control transfers take effect with a single delay slot. It holds two address registers: the address being fetched now and the address to be fetched after it. Each time the pipeline advances, the current address takes the queued one. The queued address then becomes either the transfer target or the next sequential word. A jump or call therefore redirects fetch only after the following instruction, the delay slot, has been fetched. That slot instruction runs whether it is a no-operation or useful work.

The decode stage presents three things with each advance strobe. The first is a transfer flag for the instruction at the current fetch address, covering any jump or call. The second is the target address. The third is a link request that marks a call. For a call, the block asks the register file to write the call's own address into integer register 15. The block also marks each fetch that is a delay slot. When the advance strobe is low, the sequencer stalls and all of its state holds.

Top module: `pc_seq`

## Requirements
- R1: With reset high at a clock edge (synchronous, active high), the fetch address becomes the reset vector (0 by default), the delay-slot flag is 0, and with no advance the link write enable is 0.
- R2: An advance on a non-transfer instruction whose fetch is not a delay slot moves the fetch address to the previous fetch address plus 4.
- R3: An advance on a transfer instruction at address A with target T makes the next fetch A+4 (the delay slot). The advance after that makes the fetch T.
- R4: The delay-slot flag is 1 exactly on the fetch that follows an advance whose instruction was a transfer, and 0 otherwise.
- R5: During an advance with both transfer and link request high, link_we is 1, link_idx is 5'd15, and link_data equals the current fetch address (the call's own address). The signal is combinational and lasts one cycle.
- R6: A link request without a transfer, or without an advance, leaves link_we at 0.
- R7: With the advance strobe low, the fetch address and the delay-slot flag keep their values at the clock edge, whatever the transfer, target and link inputs are.
- R8: A transfer in a delay slot is followed by one fetch at the first target (flagged as a delay slot), then by a fetch at the second target.
- R9: Address arithmetic wraps modulo 2^AW: the word after 32'hFFFFFFFC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Instruction advance strobe |
| xfer | input | 1 | Instruction at fetch_addr is a control transfer |
| target | input | AW | Transfer target address |
| link_req | input | 1 | Transfer is a call that records a return address |
| fetch_addr | output | AW | Current fetch address |
| in_slot | output | 1 | Current fetch is a delay slot |
| link_we | output | 1 | Link register write enable |
| link_idx | output | RIDX_W | Link register index (15) |
| link_data | output | AW | Value to write to the link register |

## Verification
If the queued address is wrong, the error does not show on the cycle it arises. It reaches fetch_addr one advance later, because every value passes through the queued register before it is fetched. The bench therefore compares fetch_addr and in_slot after every edge against a two-register model. That catches a corrupted queued address no more than one advance after it is written. A wrong link value or delay-slot flag shows on the same advance, so link outputs are sampled between the input change and the next edge.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int AW = 32,
  parameter int RIDX_W = 5,
  parameter int LINK_IDX = 15,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              xfer,
  input  logic [AW-1:0]     target,
  input  logic              link_req,
  output logic [AW-1:0]     fetch_addr,
  output logic              in_slot,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [AW-1:0]     link_data
);

  localparam logic [AW-1:0] WSTEP = AW'(4);

  logic [AW-1:0] pc_q, npc_q;
  logic          slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_VEC;
      npc_q  <= RESET_VEC + WSTEP;
      slot_q <= 1'b0;
    end else if (adv) begin
      pc_q   <= npc_q;
      npc_q  <= xfer ? target : npc_q + WSTEP;
      slot_q <= xfer;
    end
  end

  assign fetch_addr = pc_q;
  assign in_slot    = slot_q;
  assign link_we    = adv & xfer & link_req;
  assign link_idx   = RIDX_W'(LINK_IDX);
  assign link_data  = pc_q;

  // R2/R3: outside a delay slot the next fetch is always sequential
  a_r3_slot_seq: assert property (@(posedge clk) disable iff (rst)
    adv && !in_slot |=> fetch_addr == $past(fetch_addr) + WSTEP);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(fetch_addr) && $stable(in_slot));

  a_r6_link_needs_adv: assert property (@(posedge clk) disable iff (rst)
    link_we |-> adv && xfer);

  a_r4_call_then_slot: assert property (@(posedge clk) disable iff (rst)
    link_we |=> in_slot);

  a_r8_slot_xfer: assert property (@(posedge clk) disable iff (rst)
    adv && xfer ##1 adv |=> fetch_addr == $past(target, 2));

endmodule

// File: tb/test_pc_seq.sv
module test_pc_seq;
  logic        clk = 0, rst = 1, adv = 0, xfer = 0, link_req = 0;
  logic [31:0] target = 0;
  logic [31:0] fetch_addr, link_data;
  logic        in_slot, link_we;
  logic [4:0]  link_idx;

  int checks = 0, errors = 0;
  logic [31:0] m_pc, m_npc;
  logic        m_slot;
  bit          done = 0;

  pc_seq i_pc_seq (.clk, .rst, .adv, .xfer, .target, .link_req,
                   .fetch_addr, .in_slot, .link_we, .link_idx, .link_data);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_npc(logic [31:0] npc, logic x, logic [31:0] t);
    return x ? t : npc + 32'd4;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk({tag, " fetch_addr"}, fetch_addr, m_pc);
    chk({tag, " in_slot"}, {31'd0, in_slot}, {31'd0, m_slot});
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(logic a, logic x, logic l, logic [31:0] t, string tag);
    logic ewe;
    adv = a; xfer = x; link_req = l; target = t;
    #1;
    ewe = a & x & l;
    chk({tag, " R5 R6 link_we"}, {31'd0, link_we}, {31'd0, ewe});
    if (ewe) begin
      chk("R5 link_idx", {27'd0, link_idx}, 32'd15);
      chk("R5 link_data", link_data, m_pc);
    end
    @(posedge clk);
    if (a) begin
      m_pc = m_npc;
      m_npc = exp_npc(m_npc, x, t);
      m_slot = x;
    end
    @(negedge clk);
    chk_state(tag);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    m_pc = 0; m_npc = 4; m_slot = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 fetch_addr", fetch_addr, 32'h0);
    chk("R1 in_slot", {31'd0, in_slot}, 32'd0);
    chk("R1 link_we", {31'd0, link_we}, 32'd0);

    step(1, 0, 0, 0, "R2");
    chk("R2 sequential", fetch_addr, 32'h4);
    step(1, 1, 1, 32'h100, "R3 call");
    chk("R3 delay slot fetch", fetch_addr, 32'h8);
    chk("R4 slot flag", {31'd0, in_slot}, 32'd1);
    step(1, 0, 0, 0, "R3");
    chk("R3 redirect", fetch_addr, 32'h100);
    chk("R4 slot cleared", {31'd0, in_slot}, 32'd0);
    step(0, 1, 1, 32'h200, "R7");
    chk("R7 hold", fetch_addr, 32'h100);
    step(1, 0, 1, 32'h300, "R6");
    chk("R6 no redirect", fetch_addr, 32'h104);
    step(1, 1, 0, 32'h300, "R8");
    step(1, 1, 0, 32'h400, "R8");
    chk("R8 first target", fetch_addr, 32'h300);
    chk("R8 first target slot", {31'd0, in_slot}, 32'd1);
    step(1, 0, 0, 0, "R8");
    chk("R8 second target", fetch_addr, 32'h400);
    step(1, 1, 0, 32'hFFFF_FFFC, "R9");
    step(1, 0, 0, 0, "R9");
    chk("R9 top word", fetch_addr, 32'hFFFF_FFFC);
    step(1, 0, 0, 0, "R9");
    chk("R9 wrap", fetch_addr, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic a, x, l;
      a = ($urandom % 4) != 0;
      x = ($urandom % 3) == 0;
      l = $urandom % 2;
      step(a, x, l, {$urandom} & 32'hFFFF_FFFC, "R2 R3 R4 R7 R8 random");
    end

    rst = 1;
    @(negedge clk);
    rst = 0;
    m_pc = 0; m_npc = 4; m_slot = 0;
    chk_state("R1 re-reset");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule